// File: doc/BRIEF.md
# Interrupt Flag and Request Logic

This block keeps three interrupt flags (periodic, alarm and update-ended) next to their three enable bits. From them it forms one summary request flag, and it drives an active-low open-drain interrupt request line. Three single-cycle event pulses come from elsewhere in the clock. Each pulse records its source in a flag, whether or not that source is enabled. The flags and the summary bit are returned as an 8-bit status byte, which the bus logic presents when the processor reads the status register.

Reading the status register acknowledges everything it shows. While a read is in progress the shown flags are frozen, and any new event is parked in a per-source hold bit. When the read ends, the shown flags are dropped and the parked events become the new flag contents. This way no event is lost and no event appears half-way through a read. A separate host reset input clears the periodic and alarm enables and the update-ended flag, and through them the summary flag. It leaves the other flags and the update enable alone. The synchronous power-on reset `rst_n` clears all state.

Top module: `irq_flag_ctl`

## Requirements
- R1: An event pulse sampled while no status read is active or ending sets its flag on that clock edge, whatever the value of its enable bit.
- R2: The summary flag equals the OR over the three sources of (flag AND enable). `irq_oe` is high exactly while the summary flag is high, and `irq_o` is always 0.
- R3: Status byte layout in `regc_q`: bit 7 summary, bit 6 periodic flag, bit 5 alarm flag, bit 4 update-ended flag, bits 3 to 0 read as zero.
- R4: While `regc_rd` is high, the flag bits shown in `regc_q` do not change, even when events arrive.
- R5: In the first cycle after `regc_rd` falls, every flag shown during the read is cleared on the clock edge, and the summary flag and `irq_oe` drop with it when nothing was held.
- R6: An event that arrives while `regc_rd` is high is held and appears as a set flag from the edge that ends the read.
- R7: An event pulse in the same cycle in which the read ends is not lost: its flag is set on that edge.
- R8: While `host_rst_n` is low, the periodic and alarm enables (`en_q` bits 2 and 1) and the update-ended flag are cleared. The periodic flag, the alarm flag and the update enable (`en_q` bit 0) keep their values.
- R9: With `en_we` high, `en_wdata` is loaded into the enables on the clock edge (bit 2 periodic, bit 1 alarm, bit 0 update) and is shown on `en_q`.
- R10: The host reset takes priority in its cycle. A write to the periodic or alarm enable and an update event in that same cycle are discarded, while a write to the update enable is still accepted.
- R11: With `rst_n` low at a clock edge, all flags, hold bits and enables become 0, so `regc_q` is 0 and `irq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset, clears all state |
| host_rst_n | input | 1 | Synchronous active-low host reset, partial clear |
| evt_periodic | input | 1 | One-cycle periodic event pulse |
| evt_alarm | input | 1 | One-cycle alarm event pulse |
| evt_update | input | 1 | One-cycle update-ended event pulse |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 3 | Enable write data: periodic, alarm, update |
| en_q | output | 3 | Current enables: periodic, alarm, update |
| regc_rd | input | 1 | High for the whole duration of a status read |
| regc_q | output | 8 | Status byte |
| irq_oe | output | 1 | Drive enable of the open-drain request pin |
| irq_o | output | 1 | Data value of the request pin, constant 0 |

## Verification
Three functions can land on the same clock edge: the end of a status read, a new event, and the host reset. The bench raises an update event in exactly the cycle in which `regc_rd` has just fallen. It then expects the acknowledged flags to disappear while that single new flag survives. In a separate case it asserts the host reset together with an enable write and an update event. There it judges from `en_q` and `regc_q` that reset won for the periodic, alarm and update-flag fields, and that the update enable write still landed.

// File: rtl/irq_flag_pkg.sv
// Package irq_flag_pkg
// Shared indices and widths for the interrupt flag logic.
// Assumes three interrupt sources, numbered from the lowest status bit upward.
package irq_flag_pkg;
    localparam int SRC_N = 3;

    typedef enum int {
        SRC_UPD = 0,
        SRC_ALM = 1,
        SRC_PER = 2
    } src_e;

    localparam int STAT_W     = 8;
    localparam int FLAG_LSB   = 4;
    localparam int SUMMARY_IX = STAT_W - 1;
endpackage

// File: rtl/irq_flag_cell.sv
// Module irq_flag_cell
// One interrupt flag with a hold bit for events that arrive during a status read.
// Assumes rd_active is high for the full read and that rd_done is a one-cycle
// pulse in the cycle after the read ends. func_clr is a synchronous clear
// that takes priority over everything except the power-on reset.
module irq_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic func_clr,
    input  logic evt,
    input  logic rd_active,
    input  logic rd_done,
    output logic flag_q
);
    logic hold_q;

    // Flag and hold update: reset, host clear, read end, read hold, idle set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            hold_q <= 1'b0;
        end else if (func_clr) begin
            flag_q <= 1'b0;
            hold_q <= 1'b0;
        end else if (rd_done) begin
            flag_q <= hold_q | evt;
            hold_q <= 1'b0;
        end else if (rd_active) begin
            hold_q <= hold_q | evt;
        end else begin
            flag_q <= flag_q | evt;
        end
    end

    // R1: idle event sets the flag
    p_evt_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !rd_active && !rd_done && !func_clr) |=> flag_q);

    // R4: shown flag frozen during a read
    p_read_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active && !func_clr) |=> $stable(flag_q));

    // R7: event at read end survives
    p_end_evt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && evt && !func_clr) |=> flag_q);

    // R8: host clear empties the flag
    p_func_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        func_clr |=> !flag_q);
endmodule

// File: rtl/irq_enable_reg.sv
// Module irq_enable_reg
// Holds the per-source interrupt enables.
// Assumes the host reset clears only the bits set in CLR_MASK and that a
// write to the other bits still lands in a host-reset cycle.
module irq_enable_reg #(
    parameter int          WIDTH    = 3,
    parameter logic [2:0]  CLR_MASK = 3'b110
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_rst_n,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] en_q
);
    localparam logic [WIDTH-1:0] MASK = CLR_MASK[WIDTH-1:0];

    // Enable update per bit: write, then host-reset mask on top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            for (int i = 0; i < WIDTH; i++) begin
                if (!host_rst_n && MASK[i]) begin
                    en_q[i] <= 1'b0;
                end else if (we) begin
                    en_q[i] <= wdata[i];
                end
            end
        end
    end

    // R8: host reset clears the masked enables
    p_host_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rst_n |=> ((en_q & MASK) == '0));

    // R9: write outside host reset loads the data
    p_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rst_n && we) |=> (en_q == $past(wdata)));
endmodule

// File: rtl/irq_od_driver.sv
// Module irq_od_driver
// Models an active-low open-drain request pin as a drive enable plus a
// constant low data value. Assumes an external pull-up outside the block.
module irq_od_driver (
    input  logic req,
    output logic pin_oe,
    output logic pin_o
);
    // Pin drive: pull low only while a request is pending.
    always_comb begin
        pin_oe = req;
        pin_o  = 1'b0;
    end
endmodule

// File: rtl/irq_flag_ctl.sv
// Module irq_flag_ctl
// Top of the interrupt flag logic: three flag cells, the enable register,
// the summary flag, the status byte and the open-drain request driver.
// Assumes regc_rd is decoded outside and stays high for the whole read.
module irq_flag_ctl
    import irq_flag_pkg::*;
#(
    parameter logic [2:0] FLAG_HOST_CLR = 3'b001,
    parameter logic [2:0] EN_HOST_CLR   = 3'b110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_rst_n,
    input  logic              evt_periodic,
    input  logic              evt_alarm,
    input  logic              evt_update,
    input  logic              en_we,
    input  logic [SRC_N-1:0]  en_wdata,
    output logic [SRC_N-1:0]  en_q,
    input  logic              regc_rd,
    output logic [STAT_W-1:0] regc_q,
    output logic              irq_oe,
    output logic              irq_o
);
    logic [SRC_N-1:0] evt_v;
    logic [SRC_N-1:0] flag_v;
    logic             rd_q;
    logic             rd_done;
    logic             summary;

    // Gather the event pulses into one source-indexed vector.
    always_comb begin
        evt_v          = '0;
        evt_v[SRC_UPD] = evt_update;
        evt_v[SRC_ALM] = evt_alarm;
        evt_v[SRC_PER] = evt_periodic;
    end

    // Read tracker: remembers that the previous cycle was part of a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= 1'b0;
        end else begin
            rd_q <= regc_rd;
        end
    end

    // Read-end pulse: first cycle with the strobe low after a read.
    always_comb begin
        rd_done = rd_q && !regc_rd;
    end

    for (genvar g = 0; g < SRC_N; g++) begin : g_src
        logic clr_g;
        if (FLAG_HOST_CLR[g]) begin : g_clr
            assign clr_g = !host_rst_n;
        end else begin : g_keep
            assign clr_g = 1'b0;
        end
        irq_flag_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .func_clr  (clr_g),
            .evt       (evt_v[g]),
            .rd_active (regc_rd),
            .rd_done   (rd_done),
            .flag_q    (flag_v[g])
        );
    end

    irq_enable_reg #(
        .WIDTH    (SRC_N),
        .CLR_MASK (EN_HOST_CLR)
    ) u_en (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_rst_n (host_rst_n),
        .we         (en_we),
        .wdata      (en_wdata),
        .en_q       (en_q)
    );

    // Summary flag: any source that is both flagged and enabled.
    always_comb begin
        summary = |(flag_v & en_q);
    end

    // Status byte assembly: summary on top, flags above the zero field.
    always_comb begin
        regc_q                              = '0;
        regc_q[FLAG_LSB +: SRC_N]           = flag_v;
        regc_q[SUMMARY_IX]                  = summary;
    end

    irq_od_driver u_od (
        .req    (summary),
        .pin_oe (irq_oe),
        .pin_o  (irq_o)
    );

    // R2: request only with a flagged and enabled source
    p_req_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_oe |-> ((regc_q[FLAG_LSB +: SRC_N] & en_q) != '0));

    // R3: low status bits are zero
    p_low_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        regc_q[FLAG_LSB-1:0] == '0);

    // R8: host reset leaves no request pending
    p_host_norq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rst_n |=> !irq_oe);
endmodule

// File: tb/sim_irq_flag_ctl.sv
module sim_irq_flag_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_rst_n = 1'b1;
    logic       evt_periodic = 1'b0;
    logic       evt_alarm = 1'b0;
    logic       evt_update = 1'b0;
    logic       en_we = 1'b0;
    logic [2:0] en_wdata = 3'b000;
    logic [2:0] en_q;
    logic       regc_rd = 1'b0;
    logic [7:0] regc_q;
    logic       irq_oe;
    logic       irq_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    irq_flag_ctl u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_rst_n   (host_rst_n),
        .evt_periodic (evt_periodic),
        .evt_alarm    (evt_alarm),
        .evt_update   (evt_update),
        .en_we        (en_we),
        .en_wdata     (en_wdata),
        .en_q         (en_q),
        .regc_rd      (regc_rd),
        .regc_q       (regc_q),
        .irq_oe       (irq_oe),
        .irq_o        (irq_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_en(input logic [2:0] v);
        en_we = 1'b1; en_wdata = v;
        tick();
        en_we = 1'b0;
    endtask

    task automatic pulse(input bit p, input bit a, input bit u);
        evt_periodic = p; evt_alarm = a; evt_update = u;
        tick();
        evt_periodic = 0; evt_alarm = 0; evt_update = 0;
    endtask

    task automatic do_read();
        regc_rd = 1'b1;
        tick();
        regc_rd = 1'b0;
        tick();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        chk("R11 status", regc_q, 8'h00);
        chk("R11 irq_oe", {7'b0, irq_oe}, 8'h00);
        chk("R11 enables", {5'b0, en_q}, 8'h00);
    endtask

    task automatic t_set_disabled();
        pulse(1, 0, 0);
        chk("R1 R3 periodic bit6", regc_q, 8'h40);
        pulse(0, 1, 0);
        chk("R1 R3 alarm bit5", regc_q, 8'h60);
        pulse(0, 0, 1);
        chk("R1 R3 update bit4", regc_q, 8'h70);
        chk("R2 no request when disabled", {7'b0, irq_oe}, 8'h00);
        do_read();
        chk("R5 read clears all", regc_q, 8'h00);
    endtask

    task automatic t_summary();
        wr_en(3'b010);
        chk("R9 enable readback", {5'b0, en_q}, 8'h02);
        pulse(0, 1, 0);
        chk("R2 summary bit7", regc_q, 8'hA0);
        chk("R2 irq_oe", {7'b0, irq_oe}, 8'h01);
        chk("R2 irq_o low", {7'b0, irq_o}, 8'h00);
        do_read();
        chk("R5 cleared after read", regc_q, 8'h00);
        chk("R5 request released", {7'b0, irq_oe}, 8'h00);
        wr_en(3'b000);
    endtask

    task automatic t_read_hold();
        pulse(0, 0, 1);
        regc_rd = 1'b1;
        tick();
        chk("R4 shown at read start", regc_q, 8'h10);
        evt_periodic = 1'b1;
        tick();
        evt_periodic = 1'b0;
        chk("R4 stable during read", regc_q, 8'h10);
        tick();
        chk("R4 still stable", regc_q, 8'h10);
        regc_rd = 1'b0;
        tick();
        chk("R6 held event applied", regc_q, 8'h40);
        do_read();
    endtask

    task automatic t_end_event();
        pulse(0, 1, 0);
        regc_rd = 1'b1;
        tick();
        regc_rd = 1'b0;
        evt_update = 1'b1;
        tick();
        evt_update = 1'b0;
        chk("R7 event at read end", regc_q, 8'h10);
        do_read();
    endtask

    task automatic t_host_reset();
        wr_en(3'b111);
        pulse(1, 1, 1);
        chk("R2 all set", regc_q, 8'hF0);
        host_rst_n = 1'b0;
        tick();
        host_rst_n = 1'b1;
        chk("R8 status after host reset", regc_q, 8'h60);
        chk("R8 enables after host reset", {5'b0, en_q}, 8'h01);
        chk("R8 request cleared", {7'b0, irq_oe}, 8'h00);
    endtask

    task automatic t_priority();
        host_rst_n = 1'b0;
        en_we = 1'b1; en_wdata = 3'b110;
        evt_update = 1'b1;
        tick();
        host_rst_n = 1'b1; en_we = 1'b0; evt_update = 1'b0;
        chk("R10 enables under reset", {5'b0, en_q}, 8'h00);
        chk("R10 update event dropped", regc_q, 8'h60);
        do_read();
    endtask

    initial begin
        tick();
        t_reset();
        t_set_disabled();
        t_summary();
        t_read_hold();
        t_end_event();
        t_host_reset();
        t_priority();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule